// File: doc/BRIEF.md
# Multiplexed Address/Data Burst Read Slave

This block answers synchronous burst reads on a 16-bit bus whose lines carry first the address and then the data. A 32-bit read address reaches it in up to two clocked phases on those same lines: an optional phase for the upper half and a required phase for the lower half. Two active-low strobes tell the phases apart, address-valid (`avd_n`) and output-enable (`oe_n`). When the upper-half phase is left out, the upper half held from an earlier access is used again, so a master whose upper address does not change needs only one address cycle per access.

After the lower half is captured, a latency counter runs for a fixed number of cycles. The block then streams words from a small internal array, one per clock. There are two burst orders: wrapped inside an aligned window of 8 or 16 words, or continuous with a pause at every 8-word line boundary. A ready output marks the words, either in the cycle that carries each word or one cycle ahead of it. The data drivers turn on only while the access is live and output-enable is low. Raising chip-enable ends the access at once.

Top module: `madb_read_slave`

## Requirements
- R1: A rising edge with `ce_n`=0, `avd_n`=0 and `oe_n`=1 captures `ad_in` as the low address half and starts an access. The first word appears exactly LATENCY edges later (default 4), and `rdy` stays 0 before then. The word for 32-bit address A is ((idx*16'h2F1B) mod 2^16) XOR 16'hC35A, where idx = {A[17:16], A[4:0]}.
- R2: A rising edge with `ce_n`=0, `avd_n`=0 and `oe_n`=0 captures `ad_in` as the high address half, and the next access uses it.
- R3: When an access has no high-half phase, the high half captured most recently is used with the new low half, including across a chip-enable release.
- R4: `ad_oe` stays 0 until a low-half capture has been seen since reset or since the last chip-enable release. After that capture, `ad_oe` goes to 1 in the first cycle with `oe_n`=0 and `avd_n`=1.
- R5: After `oe_n` has driven the bus and then returned high, later `oe_n`=0 cycles leave `ad_oe` at 0 until the next low-half capture, which clears this lock.
- R6: In continuous mode (`wrap_mode`=0) the address increases by one per word. After the word at line offset 7 (address bits [2:0] all 1), exactly LATENCY cycles without data and with `rdy`=0 pass before the next line's first word.
- R7: In wrapped mode (`wrap_mode`=1) only address bits [2:0] (`wrap_len16`=0) or bits [3:0] (`wrap_len16`=1) advance, wrapping within the aligned window, and words arrive on back-to-back cycles with no pause.
- R8: With `rdy_early`=0, `rdy` is 1 exactly in the cycles that carry a word. With `rdy_early`=1, `rdy` is 1 exactly in the cycle before each word.
- R9: `ce_n`=1 forces `ad_oe` and `rdy` to 0 at once and aborts the burst. No word and no ready appears afterwards until a new low-half capture.
- R10: `ad_oe` is 0 in every cycle with `avd_n`=0, including a high-half phase that follows a live access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Active-low chip enable |
| avd_n | input | 1 | Active-low address-valid strobe |
| oe_n | input | 1 | Active-low output enable; during address-valid it selects the high-half phase |
| ad_in | input | 16 | Shared lines as received (address halves) |
| ad_out | output | 16 | Word driven onto the shared lines, zero while not driving |
| ad_oe | output | 1 | Driver enable for the shared lines |
| rdy | output | 1 | Ready, with timing selected by `rdy_early` |
| wrap_mode | input | 1 | 1 = wrapped burst, 0 = continuous burst |
| wrap_len16 | input | 1 | Wrap window: 1 = 16 words, 0 = 8 words |
| rdy_early | input | 1 | 1 = ready one cycle before the word, 0 = with the word |

## Verification
The assertions assume the mode pins `wrap_mode`, `wrap_len16` and `rdy_early` stay constant during a burst. They also assume `ad_in` is valid at every edge where `avd_n` is low. The stimulus changes the mode pins only while chip-enable is released, and it drives the address value in the same step as the strobes. Every input change is made away from the clock edge, so each phase is sampled whole by exactly one edge. The ready check in the cycle after the last expected word is left out in early mode, because the burst goes on and the master ends it by releasing chip-enable.

// File: rtl/madb_pkg.sv
package madb_pkg;

  localparam int WORD_W   = 16;
  localparam int ADDR_W   = 2 * WORD_W;
  localparam int LINE_W   = 3;   // 8-word line
  localparam int WRAP_S_W = 3;   // 8-word wrap window
  localparam int WRAP_L_W = 4;   // 16-word wrap window

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_WAIT = 2'd1,
    SQ_DATA = 2'd2
  } seq_st_t;

  // Word stored at a given array index.
  function automatic logic [WORD_W-1:0] rom_word(input logic [WORD_W-1:0] idx);
    logic [WORD_W-1:0] prod;
    prod = idx * 16'h2F1B;
    return prod ^ 16'hC35A;
  endfunction

  // Array index built from the low bits of each address half.
  function automatic logic [ADDR_W-1:0] rom_index(input logic [ADDR_W-1:0] a,
                                                  input int lo_w, input int hi_w);
    logic [ADDR_W-1:0] lo_mask, hi_mask;
    lo_mask = (ADDR_W'(1) << lo_w) - ADDR_W'(1);
    hi_mask = (ADDR_W'(1) << hi_w) - ADDR_W'(1);
    return (((a >> WORD_W) & hi_mask) << lo_w) | (a & lo_mask);
  endfunction

  // Increment only the low w bits, keeping the rest fixed.
  function automatic logic [ADDR_W-1:0] wrap_inc(input logic [ADDR_W-1:0] a, input int w);
    logic [ADDR_W-1:0] m;
    m = (ADDR_W'(1) << w) - ADDR_W'(1);
    return (a & ~m) | ((a + ADDR_W'(1)) & m);
  endfunction

  function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a,
                                                  input logic wrap, input logic len16);
    if (!wrap)      return a + ADDR_W'(1);
    else if (len16) return wrap_inc(a, WRAP_L_W);
    else            return wrap_inc(a, WRAP_S_W);
  endfunction

  function automatic logic line_last(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] m;
    m = (ADDR_W'(1) << LINE_W) - ADDR_W'(1);
    return (a & m) == m;
  endfunction

endpackage

// File: rtl/madb_addr_port.sv
module madb_addr_port
  import madb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              avd_n,
  input  logic              oe_n,
  input  logic [WORD_W-1:0] ad_in,
  output logic              lo_cap,
  output logic [ADDR_W-1:0] cap_addr,
  output logic              drive_en
);

  logic [WORD_W-1:0] hi_q;
  logic lo_seen, oe_used, oe_lock;
  logic hi_cap, oe_release;

  // Phase decode
  assign hi_cap     = !ce_n && !avd_n && !oe_n;
  assign lo_cap     = !ce_n && !avd_n &&  oe_n;
  assign cap_addr   = {hi_q, ad_in};
  assign oe_release = !ce_n && avd_n && oe_n && oe_used;
  assign drive_en   = !ce_n && avd_n && !oe_n && lo_seen && !oe_lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hi_q <= '0;
    else if (hi_cap) hi_q <= ad_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lo_seen <= 1'b0;
    else if (ce_n)   lo_seen <= 1'b0;
    else if (lo_cap) lo_seen <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_used <= 1'b0;
      oe_lock <= 1'b0;
    end else if (ce_n || lo_cap) begin
      oe_used <= 1'b0;
      oe_lock <= 1'b0;
    end else begin
      if (drive_en)   oe_used <= 1'b1;
      if (oe_release) oe_lock <= 1'b1;
    end
  end

  p_hi_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hi_cap |=> hi_q == $past(ad_in));

  p_hi_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_cap |=> $stable(hi_q));

  p_ce_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> !lo_seen);

  p_lock_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_lock && !ce_n && !lo_cap) |=> oe_lock);

  p_lo_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lo_cap |=> (lo_seen && !oe_lock));

endmodule

// File: rtl/madb_burst_seq.sv
module madb_burst_seq
  import madb_pkg::*;
#(
  parameter int LATENCY = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              wrap_mode,
  input  logic              wrap_len16,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              dvalid,
  output logic              rdy_pred
);

  localparam int CNT_W = (LATENCY < 2) ? 1 : $clog2(LATENCY + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(LATENCY - 1);

  seq_st_t st;
  logic [CNT_W-1:0] wcnt;
  logic at_stall;

  // A continuous burst pauses after the last word of a line.
  assign at_stall = (st == SQ_DATA) && !wrap_mode && line_last(cur_addr);
  assign dvalid   = (st == SQ_DATA);
  assign rdy_pred = ((st == SQ_DATA) && !at_stall) ||
                    ((st == SQ_WAIT) && (wcnt == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= SQ_IDLE;
      wcnt     <= '0;
      cur_addr <= '0;
    end else if (ce_n) begin
      st <= SQ_IDLE;
    end else if (start) begin
      st       <= SQ_WAIT;
      wcnt     <= RELOAD;
      cur_addr <= start_addr;
    end else begin
      case (st)
        SQ_WAIT: begin
          if (wcnt == '0) st <= SQ_DATA;
          else            wcnt <= wcnt - CNT_W'(1);
        end
        SQ_DATA: begin
          cur_addr <= next_addr(cur_addr, wrap_mode, wrap_len16);
          if (at_stall) begin
            st   <= SQ_WAIT;
            wcnt <= RELOAD;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  p_start_blank_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !ce_n) |=> !dvalid);

  p_wait_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_WAIT) |-> (wcnt <= RELOAD));

  p_cont_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (at_stall && !ce_n && !start) |=> (!dvalid && wcnt == RELOAD));

  p_wrap_no_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dvalid && wrap_mode && !ce_n && !start) |=> dvalid);

  p_early_rdy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_pred && !ce_n && !start) |=> dvalid);

  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> (st == SQ_IDLE));

endmodule

// File: rtl/madb_word_rom.sv
module madb_word_rom
  import madb_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [WORD_W-1:0] word
);

  localparam int DEPTH = 1 << IDX_W;

  logic [WORD_W-1:0] table_w [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    assign table_w[i] = rom_word(WORD_W'(i));
  end

  assign word = table_w[idx];

endmodule

// File: rtl/madb_read_slave.sv
module madb_read_slave
  import madb_pkg::*;
#(
  parameter int LATENCY  = 4,
  parameter int LO_IDX_W = 5,
  parameter int HI_IDX_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              avd_n,
  input  logic              oe_n,
  input  logic [WORD_W-1:0] ad_in,
  output logic [WORD_W-1:0] ad_out,
  output logic              ad_oe,
  output logic              rdy,
  input  logic              wrap_mode,
  input  logic              wrap_len16,
  input  logic              rdy_early
);

  localparam int IDX_W = LO_IDX_W + HI_IDX_W;

  logic              lo_cap;
  logic [ADDR_W-1:0] cap_addr;
  logic              drive_en;
  logic [ADDR_W-1:0] cur_addr;
  logic              dvalid;
  logic              rdy_pred;
  logic [IDX_W-1:0]  rom_idx;
  logic [WORD_W-1:0] rom_q;

  madb_addr_port u_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .avd_n    (avd_n),
    .oe_n     (oe_n),
    .ad_in    (ad_in),
    .lo_cap   (lo_cap),
    .cap_addr (cap_addr),
    .drive_en (drive_en)
  );

  madb_burst_seq #(.LATENCY(LATENCY)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_n       (ce_n),
    .start      (lo_cap),
    .start_addr (cap_addr),
    .wrap_mode  (wrap_mode),
    .wrap_len16 (wrap_len16),
    .cur_addr   (cur_addr),
    .dvalid     (dvalid),
    .rdy_pred   (rdy_pred)
  );

  assign rom_idx = IDX_W'(rom_index(cur_addr, LO_IDX_W, HI_IDX_W));

  madb_word_rom #(.IDX_W(IDX_W)) u_rom (
    .idx  (rom_idx),
    .word (rom_q)
  );

  assign ad_oe  = drive_en;
  assign ad_out = drive_en ? rom_q : '0;
  assign rdy    = !ce_n && (rdy_early ? rdy_pred : dvalid);

  p_bus_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!avd_n || ce_n) |-> !ad_oe);

  p_rdy_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !rdy);

  p_late_rdy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy_early && rdy) |-> dvalid);

endmodule

// File: tb/test_madb_read_slave.sv
module test_madb_read_slave;

  localparam int LAT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, avd_n = 1'b1, oe_n = 1'b1;
  logic [15:0] ad_in = '0;
  logic [15:0] ad_out;
  logic ad_oe, rdy;
  logic wrap_mode = 1'b0, wrap_len16 = 1'b0, rdy_early = 1'b0;

  madb_read_slave #(.LATENCY(LAT)) i_madb_read_slave (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .avd_n(avd_n), .oe_n(oe_n),
    .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .rdy(rdy),
    .wrap_mode(wrap_mode), .wrap_len16(wrap_len16), .rdy_early(rdy_early)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    int          at;
    logic [15:0] w;
    string       req;
  } exp_t;
  exp_t sb[$];
  bit   mon_on = 1'b0;
  logic [15:0] hi_ref = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Expected word from the requirement text (R1)
  function automatic logic [15:0] ref_word(input logic [31:0] a);
    logic [15:0] idx;
    logic [15:0] p;
    idx = {9'd0, a[17:16], a[4:0]};
    p = idx * 16'h2F1B;
    return p ^ 16'hC35A;
  endfunction

  function automatic logic [31:0] ref_next(input logic [31:0] a, input bit wr, input bit l16);
    if (!wr) return a + 1;
    if (l16) return {a[31:4], a[3:0] + 4'd1};
    return {a[31:3], a[2:0] + 3'd1};
  endfunction

  // Monitor: compares ready and data against the scoreboard
  always @(negedge clk) begin
    if (mon_on) begin
      int off;
      bit exp_rdy;
      bit skip;
      off = rdy_early ? 1 : 0;
      exp_rdy = 1'b0;
      foreach (sb[k]) if (sb[k].at == cyc + off) exp_rdy = 1'b1;
      skip = rdy_early && sb.size() > 0 && sb[sb.size()-1].at == cyc;
      if (!skip) chk(rdy == exp_rdy, "R8", "ready timing", 32'(rdy), 32'(exp_rdy));
      if (sb.size() > 0 && sb[0].at == cyc) begin
        exp_t e;
        e = sb.pop_front();
        chk(ad_oe == 1'b1, e.req, "driver enable on word", 32'(ad_oe), 32'd1);
        chk(ad_out == e.w, e.req, "burst word", 32'(ad_out), 32'(e.w));
      end
    end
  end

  // Driver: one access and its expected words
  task automatic run_burst(input bit with_hi, input logic [15:0] hi, input logic [15:0] lo,
                           input bit wr, input bit l16, input bit early, input int n,
                           input string req);
    logic [31:0] a;
    int t;
    wrap_mode = wr; wrap_len16 = l16; rdy_early = early;
    ce_n = 1'b0;
    if (with_hi) begin
      @(posedge clk); #2;
      avd_n = 1'b0; oe_n = 1'b0; ad_in = hi;
      hi_ref = hi;
    end
    @(posedge clk); #2;
    avd_n = 1'b0; oe_n = 1'b1; ad_in = lo;
    a = {hi_ref, lo};
    t = cyc + 1 + LAT;
    for (int k = 0; k < n; k++) begin
      exp_t e;
      e.at = t; e.w = ref_word(a); e.req = req;
      sb.push_back(e);
      if (!wr && a[2:0] == 3'd7) t = t + 1 + LAT;
      else t = t + 1;
      a = ref_next(a, wr, l16);
    end
    mon_on = 1'b1;
    @(posedge clk); #2;
    avd_n = 1'b1; oe_n = 1'b0; ad_in = '0;
    wait (sb.size() == 0);
    @(posedge clk); #2;
    mon_on = 1'b0; ce_n = 1'b1; oe_n = 1'b1;
    @(posedge clk); #2;
    ce_n = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk(ad_oe == 1'b0, "R9", "reset driver enable", 32'(ad_oe), 32'd0);
    chk(rdy == 1'b0, "R9", "reset ready", 32'(rdy), 32'd0);
    rst_n = 1'b1;
    @(posedge clk); #2;
    ce_n = 1'b0; oe_n = 1'b0; avd_n = 1'b1;
    @(negedge clk);
    chk(ad_oe == 1'b0, "R4", "no drive before low-half phase", 32'(ad_oe), 32'd0);

    // R2, R6: high phase then continuous burst over a line boundary
    run_burst(1'b1, 16'h0001, 16'h0005, 1'b0, 1'b0, 1'b0, 12, "R6");
    // R3, R7: high half reused, 8-word wrap
    run_burst(1'b0, 16'h0000, 16'h0013, 1'b1, 1'b0, 1'b0, 10, "R3");
    // R2, R7, R8: new high half, 16-word wrap, early ready
    run_burst(1'b1, 16'h0003, 16'h001A, 1'b1, 1'b1, 1'b1, 18, "R7");
    // R6, R8: continuous with early ready
    run_burst(1'b0, 16'h0000, 16'h0006, 1'b0, 1'b0, 1'b1, 10, "R6");
    // R1: plain access with another high half
    run_burst(1'b1, 16'h0002, 16'h0000, 1'b0, 1'b0, 1'b0, 3, "R1");

    // R5: output-enable lock
    wrap_mode = 1'b0; rdy_early = 1'b0;
    @(posedge clk); #2;
    avd_n = 1'b0; oe_n = 1'b1; ad_in = 16'h0008;
    @(posedge clk); #2;
    avd_n = 1'b1; oe_n = 1'b0;
    repeat (LAT + 1) @(posedge clk);
    @(negedge clk);
    chk(ad_oe == 1'b1, "R4", "drive after low-half phase", 32'(ad_oe), 32'd1);
    @(posedge clk); #2; oe_n = 1'b1;
    @(posedge clk); #2; oe_n = 1'b0;
    begin
      bit any_oe;
      bit any_rdy;
      any_oe = 1'b0; any_rdy = 1'b0;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        any_oe |= ad_oe;
        any_rdy |= rdy;
      end
      chk(any_oe == 1'b0, "R5", "second output-enable ignored", 32'(any_oe), 32'd0);
      chk(any_rdy == 1'b1, "R5", "burst still running while locked", 32'(any_rdy), 32'd1);
    end
    @(posedge clk); #2;
    avd_n = 1'b0; oe_n = 1'b1; ad_in = 16'h0010;
    @(posedge clk); #2;
    avd_n = 1'b1; oe_n = 1'b0;
    @(negedge clk);
    chk(ad_oe == 1'b1, "R5", "lock released by new low half", 32'(ad_oe), 32'd1);

    // R10: high-half phase during a live access keeps the bus released
    @(posedge clk); #2;
    avd_n = 1'b0; oe_n = 1'b0; ad_in = 16'h0002;
    @(negedge clk);
    chk(ad_oe == 1'b0, "R10", "no drive in address phase", 32'(ad_oe), 32'd0);
    @(posedge clk); #2;
    avd_n = 1'b1; oe_n = 1'b1;

    // R9: chip-enable abort mid-burst
    @(posedge clk); #2;
    avd_n = 1'b0; oe_n = 1'b1; ad_in = 16'h0000;
    @(posedge clk); #2;
    avd_n = 1'b1; oe_n = 1'b0;
    repeat (LAT + 2) @(posedge clk);
    @(negedge clk);
    chk(rdy == 1'b1, "R9", "burst live before abort", 32'(rdy), 32'd1);
    @(posedge clk); #2; ce_n = 1'b1;
    @(negedge clk);
    chk(ad_oe == 1'b0, "R9", "drive off at abort", 32'(ad_oe), 32'd0);
    chk(rdy == 1'b0, "R9", "ready off at abort", 32'(rdy), 32'd0);
    @(posedge clk); #2; ce_n = 1'b0; oe_n = 1'b0; avd_n = 1'b1;
    for (int k = 0; k < LAT + 3; k++) begin
      @(negedge clk);
      chk(ad_oe == 1'b0, "R9", "no drive after abort", 32'(ad_oe), 32'd0);
      chk(rdy == 1'b0, "R9", "no ready after abort", 32'(rdy), 32'd0);
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule